// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank, 32-bit DDR SDRAM and brings the memory from power-up to its operating state. While reset is active, and for a fixed power-on delay afterwards, it keeps the clock enable low. This keeps the memory's data and strobe pins at high impedance. The delay is given in microseconds and converted to clock cycles through a clock-frequency parameter.

When the delay has elapsed, the sequencer raises the clock enable together with a NOP. It then issues the bring-up commands in a fixed order:

1. precharge of all banks
2. extended mode write that enables the DLL
3. base mode write that resets the DLL
4. a second all-bank precharge
5. two auto-refreshes
6. a final base mode write with the DLL-reset bit cleared

Every command lasts one cycle. NOPs fill the programmed recovery time that follows it. The final step is gated by a DLL lock window of at least `DLL_LOCK` cycles, counted from the DLL-reset write. Once the sequence is complete, the block raises `init_done`, and the controller may then start normal traffic.

Top module: `dinit_seq`

## Requirements
- R1: From reset, and for `PWR_CYC = CLK_MHZ*PWRUP_US` cycles after the synchronized reset release, `cke` is low and the pins carry NOP. `cke` first reads high after the (`PWR_CYC`+2)-th rising edge following the release of `rst_n`.
- R2: The first cycle with `cke` high carries a NOP. After that, `cke` stays high until the next reset.
- R3: The command code {cs_n, ras_n, cas_n, we_n} is NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001 or MODE WRITE = 0000. A precharge drives addr[10] = 1 (all banks) with every other address bit and `ba` at 0. Refresh and NOP drive zero address and bank.
- R4: After the opening NOP, the commands come in exactly this order: PRECHARGE, MODE WRITE to ba=01, MODE WRITE to ba=00 with DLL reset, PRECHARGE, AUTO REFRESH, AUTO REFRESH, MODE WRITE to ba=00.
- R5: Each command is present for exactly one cycle. Every other cycle carries NOP.
- R6: The first precharge directly follows the opening NOP. The distance from one command to the next is exactly `T_RP` after a precharge, `T_MRD` after a mode write and `T_RFC` after a refresh. All three are at least 2.
- R7: The extended mode write has ba = 01. Its addr[0] = 0 enables the DLL, addr[1] = `DRV_REDUCED`, and all other address bits are 0.
- R8: The DLL-reset mode write has ba = 00, with addr[2:0] = `BL_CODE`, addr[3] = `BT_SEL`, addr[6:4] = `CL_CODE` and addr[8] = 1. The final mode write carries the same fields with addr[8] = 0. All other address bits are 0.
- R9: `init_done` rises max(`T_MRD` cycles after the final mode write, `DLL_LOCK` cycles after the DLL-reset write) cycles after reset release. It then stays high until reset.
- R10: Asserting `rst_n` at any point forces `cke` low, NOP and `init_done` low at once. After the release, the whole sequence restarts from the power-on wait with unchanged timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address / mode value |
| init_done | output | 1 | High once the bring-up sequence is complete |

## Verification
All pins are registered and change together, so each result falls in a cycle that can be predicted from the parameters alone:

- `cke` rises on the (`PWR_CYC`+2)-th edge after reset release.
- Every later command lands exactly one recovery time after the one before it.
- `init_done` lands at the later of the two bounds in R9.

From the parameters and the requirement formulas, the reference model lays out the complete pin word for every cycle index. It compares that word at each falling edge against both instances: one instance is limited by the DLL window and one by its refresh time. A separate log then checks the command order and the gap between commands, and a reset in mid-sequence checks the immediate return to the reset state and the restart.

// File: rtl/dinit_pkg.sv
`timescale 1ns/1ps
package dinit_pkg;

  // Command code order: {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int AP_BIT      = 10;  // all-bank select during precharge
  localparam int DLL_RST_BIT = 8;   // DLL reset in the base mode value

  typedef enum logic [4:0] {
    ST_PWR,
    ST_NOP,
    ST_PRE1,
    ST_W_PRE1,
    ST_EMRS,
    ST_W_EMRS,
    ST_MRS_RST,
    ST_W_MRS_RST,
    ST_PRE2,
    ST_W_PRE2,
    ST_REF1,
    ST_W_REF1,
    ST_REF2,
    ST_W_REF2,
    ST_MRS_FIN,
    ST_W_FIN,
    ST_LOCK,
    ST_DONE
  } dinit_state_t;

endpackage

// File: rtl/dinit_rst_sync.sv
`timescale 1ns/1ps
module dinit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/dinit_delay_cnt.sv
`timescale 1ns/1ps
// Counts cycles since its start; cycle of the start is count 0.
module dinit_delay_cnt #(
  parameter int   LIMIT        = 200,
  parameter logic RUN_AT_RESET = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic [$clog2(LIMIT+1)-1:0] cycles,
  output logic                       elapsed
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] SAT  = W'(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         cnt_en;

  assign cnt_en = start || (run_q && (cnt_q != SAT));

  always_comb begin
    run_d = run_q | start;
    if (start) cnt_d = W'(1);
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= RUN_AT_RESET;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cycles  = cnt_q;
  assign elapsed = run_q && (cnt_q >= LAST);

  AST_DELAY_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && cnt_q == SAT) |=> (cnt_q == SAT)); // R9

endmodule

// File: rtl/dinit_gap_timer.sv
`timescale 1ns/1ps
// Loaded at a command cycle with (gap - 1); `last` marks the final wait cycle.
module dinit_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q <= W'(1));

  AST_GAP_IDLE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0)); // R6

endmodule

// File: rtl/dinit_cmd_drive.sv
`timescale 1ns/1ps
module dinit_cmd_drive
  import dinit_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_d,
  input  logic              done_d,
  input  logic [3:0]        cmd_d,
  input  logic [BANK_W-1:0] ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              cke_q,
  output logic              done_q,
  output logic [3:0]        cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cke_q  <= cke_d;
      done_q <= done_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/dinit_seq.sv
`timescale 1ns/1ps
module dinit_seq
  import dinit_pkg::*;
#(
  parameter int         CLK_MHZ     = 200,
  parameter int         PWRUP_US    = 200,
  parameter int         T_RP        = 3,
  parameter int         T_MRD       = 2,
  parameter int         T_RFC       = 14,
  parameter int         DLL_LOCK    = 200,
  parameter int         BANK_W      = 2,
  parameter int         ADDR_W      = 11,
  parameter logic [2:0] BL_CODE     = 3'b011,
  parameter logic       BT_SEL      = 1'b0,
  parameter logic [2:0] CL_CODE     = 3'b011,
  parameter logic       DRV_REDUCED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int T_MAX1  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int T_MAX   = (T_MAX1 > T_RFC) ? T_MAX1 : T_RFC;
  localparam int GAP_W   = $clog2(T_MAX + 1);
  localparam int PWR_W   = $clog2(PWR_CYC + 1);
  localparam int DLL_W   = $clog2(DLL_LOCK + 1);

  localparam logic [ADDR_W-1:0] MR_OPS    = ADDR_W'({CL_CODE, BT_SEL, BL_CODE});
  localparam logic [ADDR_W-1:0] MR_DLLRST = MR_OPS | (ADDR_W'(1) << DLL_RST_BIT);
  localparam logic [ADDR_W-1:0] EMR_VAL   = ADDR_W'({DRV_REDUCED, 1'b0});
  localparam logic [ADDR_W-1:0] PRE_ALL   = ADDR_W'(1) << AP_BIT;
  localparam logic [BANK_W-1:0] BA_EXT    = BANK_W'(1);

  logic               rst_i_n;
  dinit_state_t       state_q, state_d;
  logic               pwr_ok, dll_ok, gap_last;
  logic [PWR_W-1:0]   pwr_cycles;
  logic [DLL_W-1:0]   dll_cycles;
  logic               gap_load;
  logic [GAP_W-1:0]   gap_val;
  logic               cke_d, done_d;
  logic [3:0]         cmd_d, cmd_q;
  logic [BANK_W-1:0]  ba_d;
  logic [ADDR_W-1:0]  addr_d;

  dinit_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dinit_delay_cnt #(.LIMIT(PWR_CYC), .RUN_AT_RESET(1'b1)) u_pwr_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (1'b0),
    .cycles  (pwr_cycles),
    .elapsed (pwr_ok)
  );

  dinit_delay_cnt #(.LIMIT(DLL_LOCK), .RUN_AT_RESET(1'b0)) u_dll_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (state_q == ST_MRS_RST),
    .cycles  (dll_cycles),
    .elapsed (dll_ok)
  );

  dinit_gap_timer #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (gap_load),
    .load_val (gap_val),
    .last     (gap_last)
  );

  // Recovery time loaded on each command cycle
  always_comb begin
    gap_load = 1'b1;
    gap_val  = '0;
    unique case (state_q)
      ST_PRE1, ST_PRE2:               gap_val = GAP_W'(T_RP - 1);
      ST_EMRS, ST_MRS_RST, ST_MRS_FIN: gap_val = GAP_W'(T_MRD - 1);
      ST_REF1, ST_REF2:               gap_val = GAP_W'(T_RFC - 1);
      default:                        gap_load = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR:       if (pwr_ok)   state_d = ST_NOP;
      ST_NOP:                     state_d = ST_PRE1;
      ST_PRE1:                    state_d = ST_W_PRE1;
      ST_W_PRE1:    if (gap_last) state_d = ST_EMRS;
      ST_EMRS:                    state_d = ST_W_EMRS;
      ST_W_EMRS:    if (gap_last) state_d = ST_MRS_RST;
      ST_MRS_RST:                 state_d = ST_W_MRS_RST;
      ST_W_MRS_RST: if (gap_last) state_d = ST_PRE2;
      ST_PRE2:                    state_d = ST_W_PRE2;
      ST_W_PRE2:    if (gap_last) state_d = ST_REF1;
      ST_REF1:                    state_d = ST_W_REF1;
      ST_W_REF1:    if (gap_last) state_d = ST_REF2;
      ST_REF2:                    state_d = ST_W_REF2;
      ST_W_REF2:    if (gap_last) state_d = ST_MRS_FIN;
      ST_MRS_FIN:                 state_d = ST_W_FIN;
      ST_W_FIN:     if (gap_last) state_d = dll_ok ? ST_DONE : ST_LOCK;
      ST_LOCK:      if (dll_ok)   state_d = ST_DONE;
      ST_DONE:                    state_d = ST_DONE;
      default:                    state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_PWR;
    else          state_q <= state_d;
  end

  // Pin values for the upcoming state, registered in u_drive
  always_comb begin
    cke_d  = (state_d != ST_PWR);
    done_d = (state_d == ST_DONE);
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    unique case (state_d)
      ST_PRE1, ST_PRE2: begin cmd_d = CMD_PRE; addr_d = PRE_ALL; end
      ST_EMRS:          begin cmd_d = CMD_MRS; ba_d = BA_EXT; addr_d = EMR_VAL; end
      ST_MRS_RST:       begin cmd_d = CMD_MRS; addr_d = MR_DLLRST; end
      ST_MRS_FIN:       begin cmd_d = CMD_MRS; addr_d = MR_OPS; end
      ST_REF1, ST_REF2:       cmd_d = CMD_REF;
      default:          ;
    endcase
  end

  dinit_cmd_drive #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_drive (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .cke_d  (cke_d),
    .done_d (done_d),
    .cmd_d  (cmd_d),
    .ba_d   (ba_d),
    .addr_d (addr_d),
    .cke_q  (cke),
    .done_q (init_done),
    .cmd_q  (cmd_q),
    .ba_q   (ba),
    .addr_q (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cke |-> (cmd_q == CMD_NOP)); // R1
  AST_CKE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(cke) |-> (pwr_cycles == PWR_W'(PWR_CYC))); // R1
  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_i_n)
    cke |=> cke); // R2
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_q == CMD_NOP) || (cmd_q == CMD_PRE) || (cmd_q == CMD_REF) || (cmd_q == CMD_MRS)); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_q == CMD_PRE) |-> addr[AP_BIT]); // R3
  AST_SINGLE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP)); // R5
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(init_done) |-> (dll_cycles == DLL_W'(DLL_LOCK))); // R9
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_i_n)
    init_done |=> init_done); // R9

endmodule

// File: tb/dinit_seq_tb.sv
`timescale 1ns/1ps
module dinit_seq_tb;

  localparam int MHZ = 200;
  localparam int PUS = 2;
  localparam int P   = MHZ * PUS;
  // instance A: DLL window dominates
  localparam int A_RP = 3, A_MRD = 2, A_RFC = 10, A_DLL = 200;
  localparam logic [2:0] A_BL = 3'b010, A_CL = 3'b010;
  localparam logic       A_BT = 1'b1, A_DRV = 1'b0;
  // instance B: refresh time dominates
  localparam int B_RP = 4, B_MRD = 3, B_RFC = 120, B_DLL = 200;
  localparam logic [2:0] B_BL = 3'b011, B_CL = 3'b011;
  localparam logic       B_BT = 1'b0, B_DRV = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba;
  logic [10:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba;
  logic [10:0] b_addr;

  dinit_seq #(.CLK_MHZ(MHZ), .PWRUP_US(PUS), .T_RP(A_RP), .T_MRD(A_MRD), .T_RFC(A_RFC),
              .DLL_LOCK(A_DLL), .BL_CODE(A_BL), .BT_SEL(A_BT), .CL_CODE(A_CL),
              .DRV_REDUCED(A_DRV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
    .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done));

  dinit_seq #(.CLK_MHZ(MHZ), .PWRUP_US(PUS), .T_RP(B_RP), .T_MRD(B_MRD), .T_RFC(B_RFC),
              .DLL_LOCK(B_DLL), .BL_CODE(B_BL), .BT_SEL(B_BT), .CL_CODE(B_CL),
              .DRV_REDUCED(B_DRV)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
    .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done));

  int checks = 0;
  int errors = 0;
  int kcnt = 0;
  int cyc = 0;
  bit checking = 1'b0;
  int sa[0:8];
  int sb[0:8];
  logic [5:0] log_code[$];
  int         log_cyc[$];

  // Schedule from the requirements: 0 NOP/CKE rise, 1 PRE, 2 EMR, 3 MR+DLL reset,
  // 4 PRE, 5 REF, 6 REF, 7 final MR, 8 init_done
  function automatic void mk_sched(input int trp, input int tmrd, input int trfc,
                                   input int dll, output int s[0:8]);
    s[0] = P + 2;
    s[1] = s[0] + 1;
    s[2] = s[1] + trp;
    s[3] = s[2] + tmrd;
    s[4] = s[3] + tmrd;
    s[5] = s[4] + trp;
    s[6] = s[5] + trfc;
    s[7] = s[6] + trfc;
    s[8] = (s[7] + tmrd > s[3] + dll) ? s[7] + tmrd : s[3] + dll;
  endfunction

  // Word: {done, cke, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[10:0]}
  function automatic logic [18:0] exp_word(input int k, input int s[0:8],
      input logic [2:0] bl, input logic bt, input logic [2:0] cl, input logic drv);
    logic [3:0]  c = 4'b0111;
    logic [1:0]  b = 2'b00;
    logic [10:0] a = '0;
    logic [10:0] ops = {4'b0000, cl, bt, bl};
    if (k == s[1] || k == s[4]) begin c = 4'b0010; a = 11'h400; end
    if (k == s[2]) begin c = 4'b0000; b = 2'b01; a = {9'b0, drv, 1'b0}; end
    if (k == s[3]) begin c = 4'b0000; a = ops | 11'h100; end
    if (k == s[7]) begin c = 4'b0000; a = ops; end
    if (k == s[5] || k == s[6]) c = 4'b0001;
    return {(k >= s[8]), (k >= s[0]), c, b, a};
  endfunction

  function automatic string tag_for(input int k, input int s[0:8]);
    if (k >= s[8] - 1 && k <= s[8]) return "R9";
    if (k < s[0])  return "R1";
    if (k == s[0]) return "R2";
    if (k == s[1] || k == s[4]) return "R3";
    if (k == s[2]) return "R7";
    if (k == s[3] || k == s[7]) return "R8";
    if (k == s[5] || k == s[6]) return "R6";
    return "R5";
  endfunction

  task automatic cmp(input string who, input string tag, input logic [18:0] got,
                     input logic [18:0] exp, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, k, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) kcnt <= 0;
    else        kcnt <= kcnt + 1;
  end

  // Reference comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      logic [18:0] ga, gb;
      ga = {a_done, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
      gb = {b_done, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};
      if (!rst_n) begin
        cmp("A reset", "R10", ga, {2'b00, 4'b0111, 13'd0}, kcnt);
        cmp("B reset", "R10", gb, {2'b00, 4'b0111, 13'd0}, kcnt);
      end else begin
        cmp("A", tag_for(kcnt, sa), ga, exp_word(kcnt, sa, A_BL, A_BT, A_CL, A_DRV), kcnt);
        cmp("B", tag_for(kcnt, sb), gb, exp_word(kcnt, sb, B_BL, B_BT, B_CL, B_DRV), kcnt);
        if ({a_cs, a_ras, a_cas, a_we} != 4'b0111) begin
          log_code.push_back({a_cs, a_ras, a_cas, a_we, a_ba});
          log_cyc.push_back(kcnt);
        end
      end
    end
  end

  // Independent order (R4) and gap (R6) check over the logged commands of A
  task automatic check_log();
    logic [5:0] want[7] = '{6'b001000, 6'b000001, 6'b000000, 6'b001000,
                            6'b000100, 6'b000100, 6'b000000};
    int gap[6] = '{A_RP, A_MRD, A_MRD, A_RP, A_RFC, A_RFC};
    checks++;
    if (log_code.size() != 7) begin
      errors++;
      $display("FAIL R4 command count: actual %0d expected 7", log_code.size());
    end else begin
      for (int i = 0; i < 7; i++) begin
        checks++;
        if (log_code[i] !== want[i]) begin
          errors++;
          $display("FAIL R4 command %0d: actual %b expected %b", i, log_code[i], want[i]);
        end
      end
      checks++;
      if (log_cyc[0] != P + 3) begin
        errors++;
        $display("FAIL R6 first precharge: actual %0d expected %0d", log_cyc[0], P + 3);
      end
      for (int i = 0; i < 6; i++) begin
        checks++;
        if (log_cyc[i+1] - log_cyc[i] != gap[i]) begin
          errors++;
          $display("FAIL R6 gap %0d: actual %0d expected %0d", i,
                   log_cyc[i+1] - log_cyc[i], gap[i]);
        end
      end
    end
    log_code.delete();
    log_cyc.delete();
  endtask

  task automatic release_and_run(input int until_k);
    @(negedge clk); #1;
    rst_n = 1'b1;
    while (kcnt < until_k) @(negedge clk);
  endtask

  initial begin
    mk_sched(A_RP, A_MRD, A_RFC, A_DLL, sa);
    mk_sched(B_RP, B_MRD, B_RFC, B_DLL, sb);
    repeat (4) @(negedge clk);
    checking = 1'b1;
    // full run, both instances
    release_and_run(sb[8] + 10);
    check_log();
    // mid-sequence reset (R10), then a full restart
    @(negedge clk); #1;
    rst_n = 1'b0;
    release_and_run(sa[0] + 12);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    checks++;
    if ({a_cke, a_done, a_cs, a_ras, a_cas, a_we} !== 6'b000111) begin
      errors++;
      $display("FAIL R10 immediate reset: actual %b expected 000111",
               {a_cke, a_done, a_cs, a_ras, a_cas, a_we});
    end
    repeat (3) @(negedge clk);
    log_code.delete();
    log_cyc.delete();
    release_and_run(sb[8] + 10);
    check_log();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule